// File: doc/BRIEF.md
# Dual-Format SPI Register Access Port

This block is the serial front end of a radio controller's register file. An external host drives an SPI bus in mode 0 (clock idles low, data sampled on the rising clock edge, changed on the falling edge). The block turns each framed transaction into accesses on a simple parallel port made of an address, a space select, write data, a one-cycle write strobe and combinational read data. Two command formats share the bus. A one-byte command reaches a small 64-entry space of control registers. A two-byte command reaches a 1024-entry space that holds the frame buffers.

The first bit shifted in after chip select falls picks the format. Data bytes follow the command for as long as chip select stays low. Each further byte uses the next consecutive address, and the address wraps at the top of its space. Write data is committed only when a whole byte has arrived. Read data for the current location is shifted out MSB first during every data byte. SCK, MOSI and chip select are brought into the system clock domain by synchronisers, and SCK edges are found by oversampling. Each SCK half period must therefore last at least 4 system clock cycles.

Top module: `radio_spi_regport`

## Requirements
- R1: A frame whose first bit is 0 uses the short format. The command byte holds address bits [6:1] and a write flag in bit [0] (1 = write). Every following data byte goes to the short space, with `mem_sel_long` = 0 and `mem_addr` zero-extended above bit 5.
- R2: A frame whose first bit is 1 uses the long format. The 16-bit command holds the address in bits [14:5], a write flag in bit [4] (1 = write), and bits [3:0] that have no effect. Data bytes then go to the long space with `mem_sel_long` = 1.
- R3: During a read, each data byte returns on `spi_miso`, MSB first, the content of the location being addressed.
- R4: `spi_miso` is 0 during every command byte and whenever chip select is high.
- R5: While chip select stays low, each further data byte uses the next consecutive address. This holds for both reads and writes.
- R6: During a burst the long address wraps from 1023 to 0 and the short address wraps from 63 to 0.
- R7: A rise of chip select in the middle of a byte discards that byte and writes nothing for it. The next frame is decoded from its first bit.
- R8: Every complete data byte of a write frame produces exactly one write strobe, one system clock cycle wide. The address advances by one in the next cycle.
- R9: MOSI is sampled on rising SCK edges and `spi_miso` changes only after falling SCK edges. Operation is correct with SCK half periods as short as 4 system clock cycles.
- R10: While and after reset, with no frame in progress, `spi_miso` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low, frames a transaction |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| mem_addr | output | LONG_AW | Register or buffer address |
| mem_sel_long | output | 1 | 1 selects the long space, 0 the short space |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Data to write |
| mem_rdata | input | 8 | Combinational read data for `mem_addr` |

## Verification
The bench targets burst wraps at the top of each space. A design that saturated there or carried into the wrong width would write location 64 or 1024, or stick at the last entry, instead of returning to 0. It also cuts chip select mid-byte and mid-command: a design that committed partial bytes would corrupt the next location, and one that kept stale bit state would misdecode the following frame. It puts random values in the ignored low nibble of long commands and checks that command bytes read back as zero. It also runs one frame at the minimum SCK half period, where any extra pipeline stage makes the MSB of the read data arrive after the host has already sampled it.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
   localparam int BYTE_W   = 8;
   localparam int CMD_W    = 16;
   localparam int SHORT_AW = 6;

   typedef enum logic [1:0] {
      PH_CMD_HI = 2'd0,
      PH_CMD_LO = 2'd1,
      PH_DATA   = 2'd2
   } rsr_phase_e;
endpackage

// File: rtl/rsr_sync.sv
module rsr_sync #(
   parameter int                 WIDTH     = 1,
   parameter int                 STAGES    = 2,
   parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("rsr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
      else        stage_q <= {stage_q[STAGES-2:0], d};
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rsr_pin_front.sv
module rsr_pin_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic cs_idle,
   output logic sck_rise,
   output logic sck_fall,
   output logic mosi_s
);
   logic [2:0] pins_s;
   logic       sck_s, sck_q;

   rsr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b001)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_mosi, spi_sck, spi_cs_n}),
      .q     (pins_s)
   );

   assign cs_idle = pins_s[0];
   assign sck_s   = pins_s[1];
   assign mosi_s  = pins_s[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   assign sck_rise = sck_s & ~sck_q;
   assign sck_fall = ~sck_s & sck_q;
endmodule

// File: rtl/rsr_frame.sv
module rsr_frame
   import rsr_pkg::*;
#(
   parameter int LONG_AW = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_idle,
   input  logic               sck_rise,
   input  logic               sck_fall,
   input  logic               mosi_s,
   input  logic [BYTE_W-1:0]  mem_rdata,
   output logic [LONG_AW-1:0] mem_addr,
   output logic               mem_sel_long,
   output logic               mem_we,
   output logic [BYTE_W-1:0]  mem_wdata,
   output logic               spi_miso
);
   localparam int PAD_W    = LONG_AW - SHORT_AW;
   localparam int LADDR_HI = CMD_W - 2;
   localparam int LWR_BIT  = CMD_W - 2 - LONG_AW;
   localparam int CNT_W    = $clog2(BYTE_W);

   rsr_phase_e         phase_q;
   logic [CNT_W-1:0]   bit_cnt_q;
   logic [BYTE_W-1:0]  shift_in_q;
   logic [BYTE_W-1:0]  hi_byte_q;
   logic [BYTE_W-1:0]  miso_sr_q;
   logic               wr_q;
   logic               step_q;
   logic [BYTE_W-1:0]  byte_next;
   logic [CMD_W-1:0]   cmd_word;
   logic               byte_done;
   logic               unused_cmd_bits;

   assign byte_next       = {shift_in_q[BYTE_W-2:0], mosi_s};
   assign cmd_word        = {hi_byte_q, byte_next};
   assign byte_done       = sck_rise && (bit_cnt_q == CNT_W'(BYTE_W-1));
   assign unused_cmd_bits = ^{cmd_word[CMD_W-1], cmd_word[LWR_BIT-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q      <= PH_CMD_HI;
         bit_cnt_q    <= '0;
         shift_in_q   <= '0;
         hi_byte_q    <= '0;
         miso_sr_q    <= '0;
         wr_q         <= 1'b0;
         step_q       <= 1'b0;
         mem_addr     <= '0;
         mem_sel_long <= 1'b0;
         mem_we       <= 1'b0;
         mem_wdata    <= '0;
      end else begin
         mem_we <= 1'b0;
         step_q <= 1'b0;
         if (step_q) begin
            if (mem_sel_long) mem_addr <= mem_addr + LONG_AW'(1);
            else              mem_addr <= {{PAD_W{1'b0}}, mem_addr[SHORT_AW-1:0] + SHORT_AW'(1)};
         end
         if (cs_idle) begin
            phase_q   <= PH_CMD_HI;
            bit_cnt_q <= '0;
            miso_sr_q <= '0;
         end else begin
            if (sck_rise) begin
               bit_cnt_q  <= bit_cnt_q + CNT_W'(1);
               shift_in_q <= byte_next;
            end
            if (byte_done) begin
               unique case (phase_q)
                  PH_CMD_HI: begin
                     if (byte_next[BYTE_W-1]) begin
                        hi_byte_q <= byte_next;
                        phase_q   <= PH_CMD_LO;
                     end else begin
                        mem_addr     <= {{PAD_W{1'b0}}, byte_next[BYTE_W-2:1]};
                        mem_sel_long <= 1'b0;
                        wr_q         <= byte_next[0];
                        phase_q      <= PH_DATA;
                     end
                  end
                  PH_CMD_LO: begin
                     mem_addr     <= cmd_word[LADDR_HI -: LONG_AW];
                     mem_sel_long <= 1'b1;
                     wr_q         <= cmd_word[LWR_BIT];
                     phase_q      <= PH_DATA;
                  end
                  default: begin
                     mem_we    <= wr_q;
                     mem_wdata <= byte_next;
                     step_q    <= 1'b1;
                  end
               endcase
            end
            if (sck_fall && phase_q == PH_DATA) begin
               if (bit_cnt_q == '0) miso_sr_q <= mem_rdata;
               else                 miso_sr_q <= {miso_sr_q[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign spi_miso = (phase_q == PH_DATA) & miso_sr_q[BYTE_W-1];
endmodule

// File: rtl/radio_spi_regport.sv
module radio_spi_regport #(
   parameter int LONG_AW     = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spi_sck,
   input  logic               spi_cs_n,
   input  logic               spi_mosi,
   output logic               spi_miso,
   output logic [LONG_AW-1:0] mem_addr,
   output logic               mem_sel_long,
   output logic               mem_we,
   output logic [7:0]         mem_wdata,
   input  logic [7:0]         mem_rdata
);
   generate
      if (LONG_AW <= rsr_pkg::SHORT_AW || LONG_AW > rsr_pkg::CMD_W - 2) begin : g_bad_aw
         $error("radio_spi_regport: LONG_AW must exceed the short width and fit the long command");
      end
   endgenerate

   logic cs_idle, sck_rise, sck_fall, mosi_s;

   rsr_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (spi_sck),
      .spi_cs_n (spi_cs_n),
      .spi_mosi (spi_mosi),
      .cs_idle  (cs_idle),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .mosi_s   (mosi_s)
   );

   rsr_frame #(.LONG_AW(LONG_AW)) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_idle      (cs_idle),
      .sck_rise     (sck_rise),
      .sck_fall     (sck_fall),
      .mosi_s       (mosi_s),
      .mem_rdata    (mem_rdata),
      .mem_addr     (mem_addr),
      .mem_sel_long (mem_sel_long),
      .mem_we       (mem_we),
      .mem_wdata    (mem_wdata),
      .spi_miso     (spi_miso)
   );
endmodule

// File: rtl/radio_spi_regport_chk.sv
module radio_spi_regport_chk #(
   parameter int LONG_AW  = 10,
   parameter int SHORT_AW = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               spi_cs_n,
   input logic               spi_miso,
   input logic [LONG_AW-1:0] mem_addr,
   input logic               mem_sel_long,
   input logic               mem_we
);
   p_we_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   p_step_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_sel_long) |=> (mem_addr == LONG_AW'($past(mem_addr) + LONG_AW'(1))));

   p_step_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mem_sel_long) |=>
         (mem_addr == {{(LONG_AW-SHORT_AW){1'b0}}, SHORT_AW'($past(mem_addr[SHORT_AW-1:0]) + SHORT_AW'(1))}));

   p_space_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> $stable(mem_sel_long));

   p_short_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_sel_long |-> (mem_addr[LONG_AW-1:SHORT_AW] == '0));

   p_miso_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);
endmodule

bind radio_spi_regport radio_spi_regport_chk #(.LONG_AW(LONG_AW), .SHORT_AW(rsr_pkg::SHORT_AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .spi_cs_n     (spi_cs_n),
   .spi_miso     (spi_miso),
   .mem_addr     (mem_addr),
   .mem_sel_long (mem_sel_long),
   .mem_we       (mem_we)
);

// File: tb/radio_spi_regport_bench.sv
module radio_spi_regport_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic       miso;
   logic [9:0] mem_addr;
   logic       mem_sel_long, mem_we;
   logic [7:0] mem_wdata, mem_rdata;

   logic [7:0] dmem_s [64];
   logic [7:0] dmem_l [1024];
   logic [7:0] ref_s  [64];
   logic [7:0] ref_l  [1024];
   logic [7:0] txb [40];
   logic [7:0] rxb [40];

   int checks = 0, errors = 0, we_cycles = 0, exp_we = 0, hp = 8;
   bit done = 1'b0;

   radio_spi_regport u_radio_spi_regport (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .mem_addr(mem_addr), .mem_sel_long(mem_sel_long),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   assign mem_rdata = mem_sel_long ? dmem_l[mem_addr] : dmem_s[mem_addr[5:0]];

   always @(posedge clk) begin
      if (rst_n && mem_we) begin
         we_cycles++;
         if (mem_sel_long) dmem_l[mem_addr] <= mem_wdata;
         else              dmem_s[mem_addr[5:0]] <= mem_wdata;
      end
   end

   function automatic logic [7:0] short_cmd(input logic [5:0] a, input logic wr);
      return {1'b0, a, wr};
   endfunction
   function automatic logic [7:0] long_hi(input logic [9:0] a);
      return {1'b1, a[9:3]};
   endfunction
   function automatic logic [7:0] long_lo(input logic [9:0] a, input logic wr, input logic [3:0] dc);
      return {a[2:0], wr, dc};
   endfunction

   task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic frame(input int nbits);
      for (int i = 0; i < 40; i++) rxb[i] = 8'h00;
      cs_n = 1'b0;
      repeat (hp) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = txb[i/8][7-(i%8)];
         repeat (hp) @(negedge clk);
         rxb[i/8][7-(i%8)] = miso;
         sck = 1'b1;
         repeat (hp) @(negedge clk);
         sck = 1'b0;
      end
      repeat (hp) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (3*hp) @(negedge clk);
   endtask

   task automatic short_access(input logic [5:0] a, input logic wr, input int n);
      txb[0] = short_cmd(a, wr);
      for (int k = 1; k <= n; k++) txb[k] = 8'($urandom);
      frame((n + 1) * 8);
      check8("R4", "short command byte on miso", rxb[0], 8'h00);
      for (int k = 0; k < n; k++) begin
         logic [5:0] ak;
         string tag;
         ak  = a + 6'(k);
         tag = (ak < a) ? "R6" : ((k > 0) ? "R5" : (wr ? "R1" : "R3"));
         if (wr) begin
            ref_s[ak] = txb[k+1];
            exp_we++;
            check8(tag, "short write stored", dmem_s[ak], ref_s[ak]);
         end else begin
            check8(tag, "short read data", rxb[k+1], ref_s[ak]);
         end
      end
   endtask

   task automatic long_access(input logic [9:0] a, input logic wr, input int n);
      txb[0] = long_hi(a);
      txb[1] = long_lo(a, wr, 4'($urandom));
      for (int k = 2; k < n + 2; k++) txb[k] = 8'($urandom);
      frame((n + 2) * 8);
      check8("R4", "long command bytes on miso", rxb[0] | rxb[1], 8'h00);
      for (int k = 0; k < n; k++) begin
         logic [9:0] ak;
         string tag;
         ak  = a + 10'(k);
         tag = (ak < a) ? "R6" : ((k > 0) ? "R5" : (wr ? "R2" : "R3"));
         if (wr) begin
            ref_l[ak] = txb[k+2];
            exp_we++;
            check8(tag, "long write stored", dmem_l[ak], ref_l[ak]);
         end else begin
            check8(tag, "long read data", rxb[k+2], ref_l[ak]);
         end
      end
   endtask

   task automatic finish_up;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual hung expected done");
         finish_up();
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 64; i++)   begin dmem_s[i] = 8'(i * 37 + 5);  ref_s[i] = 8'(i * 37 + 5);  end
      for (int i = 0; i < 1024; i++) begin dmem_l[i] = 8'(i * 13 + 99); ref_l[i] = 8'(i * 13 + 99); end
      repeat (4) @(negedge clk);
      check8("R10", "miso during reset", {7'b0, miso}, 8'h00);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check8("R10", "miso after reset", {7'b0, miso}, 8'h00);
      check8("R10", "write strobe after reset", {7'b0, mem_we}, 8'h00);

      // R1 R3: directed short write then read back
      short_access(6'd5, 1'b1, 1);
      short_access(6'd5, 1'b0, 1);
      // R2 R3: long write and read, random ignored nibble
      long_access(10'h2A5, 1'b1, 1);
      long_access(10'h2A5, 1'b0, 1);
      // R5: bursts in both spaces
      long_access(10'd100, 1'b1, 5);
      long_access(10'd100, 1'b0, 5);
      short_access(6'd20, 1'b1, 4);
      short_access(6'd20, 1'b0, 4);
      // R6: wrap at top of each space
      long_access(10'd1022, 1'b1, 3);
      long_access(10'd1022, 1'b0, 3);
      short_access(6'd62, 1'b1, 3);
      short_access(6'd62, 1'b0, 3);
      check8("R4", "miso with chip select high", {7'b0, miso}, 8'h00);

      // R7: long write cut after 5 bits of second data byte
      txb[0] = long_hi(10'd500);
      txb[1] = long_lo(10'd500, 1'b1, 4'h0);
      txb[2] = 8'hC3;
      txb[3] = 8'h5A;
      frame(16 + 8 + 5);
      ref_l[500] = 8'hC3;
      exp_we++;
      check8("R7", "full byte before abort committed", dmem_l[500], ref_l[500]);
      check8("R7", "partial byte not committed", dmem_l[501], ref_l[501]);
      // R7: short write cut after 7 data bits
      txb[0] = short_cmd(6'd9, 1'b1);
      txb[1] = 8'hFF;
      frame(8 + 7);
      check8("R7", "short partial byte not committed", dmem_s[9], ref_s[9]);
      // R7: abort inside long command, then a fresh short read
      txb[0] = long_hi(10'd7);
      txb[1] = long_lo(10'd7, 1'b1, 4'h0);
      frame(11);
      short_access(6'd9, 1'b0, 1);

      // R9: minimum SCK half period
      hp = 4;
      long_access(10'd300, 1'b1, 2);
      long_access(10'd300, 1'b0, 2);
      short_access(6'd33, 1'b0, 2);
      hp = 8;

      // random mix
      for (int it = 0; it < 40; it++) begin
         int sel, n;
         sel = int'($urandom % 4);
         n   = 1 + int'($urandom % 4);
         case (sel)
            0: short_access(6'($urandom), 1'b1, n);
            1: short_access(6'($urandom), 1'b0, n);
            2: long_access(10'($urandom), 1'b1, n);
            default: long_access(10'($urandom), 1'b0, n);
         endcase
      end

      begin
         int bad;
         bad = 0;
         for (int i = 0; i < 64; i++)   if (dmem_s[i] !== ref_s[i]) bad++;
         for (int i = 0; i < 1024; i++) if (dmem_l[i] !== ref_l[i]) bad++;
         check8("R2", "locations differing from reference (R1 R7 too)", 8'(bad), 8'h00);
      end
      check8("R8", "write strobe cycles", 8'(we_cycles), 8'(exp_we));
      done = 1'b1;
      finish_up();
   end
endmodule